// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Sequencer

This block moves a block of words from one memory region to another under the control of a three-word descriptor held in memory. Software writes the descriptor base address and sets the enable bit. A rising peripheral request then starts a pass. The engine first fetches the control word, then the source end pointer, then the destination end pointer. It copies each word by a read followed by a write. Finally it writes the control word back with its count and mode fields cleared.

The descriptor sits at three consecutive words from the base: source end pointer at +0, destination end pointer at +4, control word at +8. The control word carries a count field (words minus one) and a mode field, where mode 0 means stop. Word k of an N-word pass is taken from the end pointer minus (N-1-k)*4, so the last word lands exactly on the end pointer. Clearing the enable bit pauses the pass after the bus access in flight. Setting it again continues from the interrupted step. A status register exposes the sequencer step as a fixed 4-bit code, the channel count and a busy flag.

Top module: `dma_engine`

## Requirements
- R1: After reset the status register (reg_addr 2) reads 0, the configuration register (reg_addr 0) reads 0 and mem_req is low.
- R2: The register port decodes reg_addr 0 as configuration (write bit 0 = enable, reads 0), 1 as descriptor base (read/write, bits 1:0 forced to 0), 2 as status (read-only; writes are ignored) and 3 as read-zero. Status bits 20:16 read channel count minus one (0), bit 0 reads 1 whenever the step code is not 0, and all other bits outside 7:4 read 0.
- R3: Status bits 7:4 show the step: 0 idle, 1 control read, 2 source end read, 3 destination end read, 4 data read, 5 data write, 6 waiting for request release, 7 control write-back, 8 suspended, 9 done. Codes 0xA to 0xF never appear.
- R4: With enable set and the engine idle, per_req high starts a pass whose bus accesses run in this order: read base+8, read base+0, read base+4, then a read/write pair per word, then a write to base+8.
- R5: With count field c = control[13:4], the pass moves c+1 words. Word k (k = 0..c) is read from src_end-(c-k)*4 and written unchanged to dst_end-(c-k)*4.
- R6: The write-back equals the fetched control word with bits 13:4 and 1:0 cleared. It is followed by exactly one cycle of code 9 and then code 0. If per_req is still high after the last data write, the engine sits in code 6 without bus activity until per_req falls.
- R7: A control word with mode field (bits 1:0) equal to 0 ends the pass in code 9 right after the control read, with no further bus access.
- R8: mem_req, mem_we, mem_addr and mem_wdata stay stable while mem_req is high and mem_ack is low. Every bus step advances only on mem_ack.
- R9: Clearing enable during a pass lets the pending access finish and then holds code 8 with mem_req low. Setting enable again resumes the remaining accesses without a new request.
- R10: A configuration write of 0 in the same cycle as a mem_ack suspends at that acknowledge, so no further access is issued.
- R11: While enable is clear and the engine is idle, per_req causes no bus access and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| per_req | input | 1 | Peripheral transfer request |
| mem_req | output | 1 | Bus access valid |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus access completed |
| mem_rdata | input | 32 | Bus read data, valid with mem_ack |

## Verification
A software disable and a bus acknowledge can land in the same clock edge. The engine then has to retire the acknowledged access and suspend at once, rather than issue one more access. The bench provokes this with a zero-wait memory. It watches the status code and, in the very cycle the code shows a data write being acknowledged, writes enable low. It then judges that the status reads suspended on the next cycle and that the scoreboard queue holds exactly the accesses still owed. After re-enable the remaining accesses must drain in order.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'h0,
        ST_CTRL_RD = 4'h1,
        ST_SRC_RD  = 4'h2,
        ST_DST_RD  = 4'h3,
        ST_DATA_RD = 4'h4,
        ST_DATA_WR = 4'h5,
        ST_REQ_CLR = 4'h6,
        ST_CTRL_WR = 4'h7,
        ST_SUSP    = 4'h8,
        ST_DONE    = 4'h9,
        ST_SG      = 4'hA
    } dma_state_e;

    // control word layout
    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 2;
    localparam int CNT_LSB  = 4;

    // register select codes
    localparam logic [1:0] SEL_CFG    = 2'd0;
    localparam logic [1:0] SEL_BASE   = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int CHANNELS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  dma_state_e       state,
    output logic             en_eff,
    output logic [AW-1:0]    base,
    output logic [DW-1:0]    reg_rdata
);

    localparam logic [4:0] CH_FIELD = 5'(CHANNELS - 1);

    typedef struct packed {
        logic          en;
        logic [AW-1:0] base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic cfg_hit;
    logic [DW-1:0] status;
    logic unused_wbit;

    assign unused_wbit = reg_wdata[1];
    assign cfg_hit = reg_we && (reg_addr == SEL_CFG);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_hit) begin
            cfg_d.en = reg_wdata[0];
        end
        if (reg_we && (reg_addr == SEL_BASE)) begin
            cfg_d.base = {reg_wdata[AW-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // a disable written this cycle already governs this cycle's edge
    assign en_eff = cfg_hit ? reg_wdata[0] : cfg_q.en;
    assign base   = cfg_q.base;

    always_comb begin
        status        = '0;
        status[20:16] = CH_FIELD;
        status[7:4]   = state;
        status[0]     = (state != ST_IDLE);
    end

    always_comb begin
        case (reg_addr)
            SEL_BASE:   reg_rdata = cfg_q.base;
            SEL_STATUS: reg_rdata = status;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              per_req,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output dma_state_e        state,
    output logic [AW-1:0]     src_end,
    output logic [AW-1:0]     dst_end,
    output logic [DW-1:0]     ctrl,
    output logic [DW-1:0]     data,
    output logic [CNT_W-1:0]  rem
);

    typedef struct packed {
        dma_state_e       st;
        dma_state_e       resume;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [DW-1:0]    ctrl;
        logic [DW-1:0]    data;
        logic [CNT_W-1:0] rem;
    } seq_t;

    seq_t seq_d, seq_q;
    dma_state_e step;
    logic fin;

    always_comb begin
        seq_d = seq_q;
        step  = seq_q.st;
        fin   = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (en && per_req) seq_d.st = ST_CTRL_RD;
            end
            ST_CTRL_RD: begin
                if (mem_ack) begin
                    fin        = 1'b1;
                    seq_d.ctrl = mem_rdata;
                    seq_d.rem  = mem_rdata[CNT_LSB +: CNT_W];
                    step = (mem_rdata[MODE_LSB +: MODE_W] == '0) ? ST_DONE : ST_SRC_RD;
                end
            end
            ST_SRC_RD: begin
                if (mem_ack) begin
                    fin       = 1'b1;
                    seq_d.src = mem_rdata[AW-1:0];
                    step      = ST_DST_RD;
                end
            end
            ST_DST_RD: begin
                if (mem_ack) begin
                    fin       = 1'b1;
                    seq_d.dst = mem_rdata[AW-1:0];
                    step      = ST_DATA_RD;
                end
            end
            ST_DATA_RD: begin
                if (mem_ack) begin
                    fin        = 1'b1;
                    seq_d.data = mem_rdata;
                    step       = ST_DATA_WR;
                end
            end
            ST_DATA_WR: begin
                if (mem_ack) begin
                    fin = 1'b1;
                    if (seq_q.rem == '0) begin
                        step = per_req ? ST_REQ_CLR : ST_CTRL_WR;
                    end else begin
                        seq_d.rem = seq_q.rem - 1'b1;
                        step      = ST_DATA_RD;
                    end
                end
            end
            ST_REQ_CLR: begin
                if (!en) begin
                    seq_d.st     = ST_SUSP;
                    seq_d.resume = ST_REQ_CLR;
                end else if (!per_req) begin
                    seq_d.st = ST_CTRL_WR;
                end
            end
            ST_CTRL_WR: begin
                if (mem_ack) begin
                    fin  = 1'b1;
                    step = ST_DONE;
                end
            end
            ST_SUSP: begin
                if (en) seq_d.st = seq_q.resume;
            end
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase

        if (fin) begin
            if (!en && step != ST_DONE) begin
                seq_d.st     = ST_SUSP;
                seq_d.resume = step;
            end else begin
                seq_d.st = step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, resume: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state   = seq_q.st;
    assign src_end = seq_q.src;
    assign dst_end = seq_q.dst;
    assign ctrl    = seq_q.ctrl;
    assign data    = seq_q.data;
    assign rem     = seq_q.rem;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 10
) (
    input  dma_state_e        state,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     src_end,
    input  logic [AW-1:0]     dst_end,
    input  logic [DW-1:0]     ctrl,
    input  logic [DW-1:0]     data,
    input  logic [CNT_W-1:0]  rem,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata
);

    localparam logic [AW-1:0] OFF_SRC  = AW'(0);
    localparam logic [AW-1:0] OFF_DST  = AW'(4);
    localparam logic [AW-1:0] OFF_CTRL = AW'(8);

    logic [AW-1:0] back;
    logic [DW-1:0] wb;

    assign back = AW'(rem) << 2;

    always_comb begin
        wb = ctrl;
        wb[CNT_LSB +: CNT_W]   = '0;
        wb[MODE_LSB +: MODE_W] = '0;
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_CTRL_RD: mem_addr = base + OFF_CTRL;
            ST_SRC_RD:  mem_addr = base + OFF_SRC;
            ST_DST_RD:  mem_addr = base + OFF_DST;
            ST_DATA_RD: mem_addr = src_end - back;
            ST_DATA_WR: begin
                mem_we    = 1'b1;
                mem_addr  = dst_end - back;
                mem_wdata = data;
            end
            ST_CTRL_WR: begin
                mem_we    = 1'b1;
                mem_addr  = base + OFF_CTRL;
                mem_wdata = wb;
            end
            default: mem_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int CNT_W    = 10,
    parameter int CHANNELS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          per_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    dma_state_e       st;
    logic             en_eff;
    logic [AW-1:0]    base, src_end, dst_end;
    logic [DW-1:0]    ctrl, data;
    logic [CNT_W-1:0] rem;

    dma_cfg_regs #(.AW(AW), .DW(DW), .CHANNELS(CHANNELS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .state     (st),
        .en_eff    (en_eff),
        .base      (base),
        .reg_rdata (reg_rdata)
    );

    dma_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_eff),
        .per_req   (per_req),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .state     (st),
        .src_end   (src_end),
        .dst_end   (dst_end),
        .ctrl      (ctrl),
        .data      (data),
        .rem       (rem)
    );

    dma_addr_gen #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_addr (
        .state     (st),
        .base      (base),
        .src_end   (src_end),
        .dst_end   (dst_end),
        .ctrl      (ctrl),
        .data      (data),
        .rem       (rem),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          per_req,
    input logic          en,
    input logic [3:0]    state
);

    p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 4'h9);

    p_hold_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    p_done_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));

    p_wait_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ_CLR && per_req && en) |=> (state == ST_REQ_CLR));

    p_suspend_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP) |-> !mem_req);

    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !en) |=> (state == ST_IDLE));

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .per_req   (per_req),
    .en        (en_eff),
    .state     (st)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    initial mem_ack = 1'b0;
    initial mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  code;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [0:63];
    int          n_vec = 0;
    int          n_err = 0;
    int          lat = 0;
    int          wcnt = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always begin
        @(negedge clk);
        #1;
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (wcnt >= lat) begin
                exp_t e;
                wcnt = 0;
                mem_ack = 1'b1;
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected access", mem_addr, 32'hx);
                end else begin
                    e = sb.pop_front();
                    check(mem_we == e.we && mem_addr == e.addr, "R4/R5 access",
                          {mem_we, mem_addr[30:0]}, {e.we, e.addr[30:0]});
                    if (e.we) check(mem_wdata == e.wdata, "R5/R6 write data", mem_wdata, e.wdata);
                    if (reg_addr == 2'd2 && !reg_we)
                        check(reg_rdata[7:4] == e.code, "R3 step code", 32'(reg_rdata[7:4]), 32'(e.code));
                end
                if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[7:2]];
            end else begin
                wcnt++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
        reg_addr = 2'd2;
    endtask

    task automatic wait_code(input logic [3:0] c, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            #2 if (reg_rdata[7:4] == c) seen = 1'b1;
        end
        check(seen, req, 32'(reg_rdata[7:4]), 32'(c));
    endtask

    task automatic wait_idle(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            #2 if (reg_rdata[7:4] == 4'h0 && sb.size() == 0) seen = 1'b1;
        end
        check(seen, req, 32'(sb.size()), 32'd0);
    endtask

    // driver: loads a descriptor and queues the expected accesses
    task automatic load_pass(input logic [31:0] s_end, input logic [31:0] d_end,
                             input int cnt, input logic [1:0] mode, input logic [31:0] extra);
        logic [31:0] cw;
        cw = (extra & 32'hFFFF_C00C) | (32'(cnt) << 4) | 32'(mode);
        mem[BASE[7:2]]     = s_end;
        mem[BASE[7:2] + 1] = d_end;
        mem[BASE[7:2] + 2] = cw;
        sb.push_back('{1'b0, BASE + 8, 32'h0, 4'h1});
        if (mode == 2'd0) return;
        sb.push_back('{1'b0, BASE, 32'h0, 4'h2});
        sb.push_back('{1'b0, BASE + 4, 32'h0, 4'h3});
        for (int k = 0; k <= cnt; k++) begin
            logic [31:0] sa, da;
            sa = s_end - 32'((cnt - k) * 4);
            da = d_end - 32'((cnt - k) * 4);
            sb.push_back('{1'b0, sa, 32'h0, 4'h4});
            sb.push_back('{1'b1, da, mem[sa[7:2]], 4'h5});
        end
        sb.push_back('{1'b1, BASE + 8, cw & 32'hFFFF_C00C, 4'h7});
    endtask

    task automatic pulse_req;
        @(negedge clk); per_req = 1'b1;
        @(negedge clk); per_req = 1'b0;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd2, r); check(r == 32'h0, "R1 status after reset", r, 32'h0);
        reg_read(2'd0, r); check(r == 32'h0, "R1 config after reset", r, 32'h0);
        check(!mem_req, "R1 no bus request", 32'(mem_req), 32'd0);

        // R2 register map
        reg_write(2'd1, BASE | 32'h3);
        reg_read(2'd1, r); check(r == BASE, "R2 base readback", r, BASE);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, r); check(r == 32'h0, "R2 status write ignored", r, 32'h0);
        reg_read(2'd3, r); check(r == 32'h0, "R2 unused select", r, 32'h0);

        // R11 disabled engine ignores requests
        pulse_req();
        repeat (5) @(negedge clk);
        #2 check(reg_rdata == 32'h0 && !mem_req, "R11 request while disabled",
                 reg_rdata, 32'h0);

        // R4 R5 R6 basic pass, zero wait, four words
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, r); check(r == 32'h0, "R2 config reads zero", r, 32'h0);
        load_pass(32'h0C, 32'h8C, 3, 2'd1, 32'hF000_0000);
        pulse_req();
        #2 check(reg_rdata[0] == 1'b1, "R2 busy flag", reg_rdata, 32'h1);
        wait_code(4'h9, "R6 done code");
        @(negedge clk); #2 check(reg_rdata[7:4] == 4'h0, "R6 done lasts one cycle",
                                 32'(reg_rdata[7:4]), 32'h0);
        wait_idle("R4 pass complete");
        check(mem[35] == 32'hA000_0003, "R5 last word placed", mem[35], 32'hA000_0003);

        // R6 R8 held request, wait states, single word
        lat = 2;
        load_pass(32'h20, 32'hA0, 0, 2'd2, 32'h0000_5000);
        @(negedge clk); per_req = 1'b1;
        wait_code(4'h6, "R6 wait for release");
        repeat (3) begin
            @(negedge clk);
            #2 check(reg_rdata[7:4] == 4'h6 && !mem_req, "R6 holds in wait",
                     {reg_rdata[7:4], 27'd0, mem_req}, 32'h6000_0000);
        end
        per_req = 1'b0;
        wait_idle("R6 release completes pass");

        // R7 mode zero stops after control read
        load_pass(32'h10, 32'h90, 2, 2'd0, 32'h0);
        pulse_req();
        wait_idle("R7 mode zero");
        check(mem[34] == 32'hA000_0002, "R7 no data moved", mem[34], 32'hA000_0002);

        // R9 suspend with a pending access, then resume
        for (int i = 0; i < 16; i++) mem[i] = 32'hB000_0000 + 32'(i);
        load_pass(32'h1C, 32'h9C, 2, 2'd3, 32'h0);
        pulse_req();
        wait_code(4'h4, "R9 reach data read");
        reg_write(2'd0, 32'h0);
        wait_code(4'h8, "R9 suspended");
        repeat (4) begin
            @(negedge clk);
            #2 check(!mem_req && reg_rdata[0], "R9 quiet while suspended",
                     {31'd0, mem_req}, 32'h0);
        end
        reg_write(2'd0, 32'h1);
        wait_idle("R9 resume completes");
        check(mem[39] == 32'hB000_0007, "R9 data after resume", mem[39], 32'hB000_0007);

        // R10 disable in the same cycle as a write acknowledge
        lat = 0;
        load_pass(32'h2C, 32'hAC, 3, 2'd1, 32'h0);
        pulse_req();
        begin
            bit hit = 1'b0;
            for (int i = 0; i < 100 && !hit; i++) begin
                @(negedge clk);
                #2 if (reg_rdata[7:4] == 4'h5) begin
                    hit = 1'b1;
                    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0;
                end
            end
            @(negedge clk);
            reg_we = 1'b0; reg_addr = 2'd2;
            #2 check(reg_rdata[7:4] == 4'h8, "R10 suspended at that acknowledge",
                     32'(reg_rdata[7:4]), 32'h8);
            check(sb.size() == 7, "R10 no extra access", 32'(sb.size()), 32'd7);
        end
        reg_write(2'd0, 32'h1);
        wait_idle("R10 resume completes");

        summary();
        $finish;
    end

endmodule